// File: doc/BRIEF.md
# Clock Synthesizer Control Register Unit

This block holds the 16-bit control and status word of an on-chip clock synthesizer and the small amount of control logic around it. Software reaches it through a simple register bus that carries a privilege qualifier. Only privileged accesses have any effect. The upper byte sets the synthesizer loop: a VCO speed tap, an output divide-by-two, and a 6-bit feedback modulus. The lower byte holds the E-clock rate select, the two stop-mode routing bits, and a read-only lock flag.

A write that changes the loop parameters emits a one-cycle relock request and clears the lock flag. The flag then stays low until the lock input from the analog loop has been sampled high on a fixed number of consecutive cycles. The lock state lives in a three-state machine:
- `LK_BOOT`: nothing has been written since reset, and the flag reads locked.
- `LK_ACQUIRE`: the machine counts a run of lock samples.
- `LK_HELD`: the loop is locked.

The transitions are:
- `LK_BOOT`→`LK_ACQUIRE` on a first write that changes the loop.
- `LK_BOOT`→`LK_HELD` on a first write that leaves the loop alone.
- `LK_ACQUIRE`→`LK_HELD` when the run completes.
- `LK_HELD`→`LK_ACQUIRE` on a loop-changing write or on loss of the lock input.
- `LK_ACQUIRE`→`LK_ACQUIRE` with the run cleared on a relock or a missing sample.

The block also produces the E-clock, which is the system clock divided by 8 or 16 and is gated by an external enable. It also resolves, during a low-power stop request, which clock drives the system-interface clock and whether the external clock output is held off.

Top module: `clk_ctrl_unit`

## Requirements
- R1: A write with the privilege qualifier low changes no register field.
- R2: A read with the qualifier low returns 0. A privileged read returns W at bit 15, X at bit 14, Y at bits 13:8, EDIV at bit 7, STSIM at bit 6, STEXT at bit 5 and the lock flag at bit 0. Bits 4:1 read 0. Outside a read, the read data is 0.
- R3: After reset, W=0, X=0, Y=0x3F, EDIV=STSIM=STEXT=0, the relock request is 0 and the lock flag reads 1.
- R4: A privileged write whose W or Y differs from the stored value drives the relock request high for exactly the next cycle. The lock flag reads 0 from that cycle on, unless the VCO is off.
- R5: A privileged write that leaves W and Y unchanged raises no relock request. The new X and the lower-byte fields still take effect.
- R6: Until the first privileged write after reset, the lock flag reads 1 whatever the lock input does.
- R7: After a relock, the lock flag returns to 1 only after the lock input has been sampled high on LOCK_CYCLES (4) consecutive clock edges. A low sample restarts the count. A low lock input while locked clears the flag.
- R8: While the VCO is switched off by a stop, the lock flag reads 1.
- R9: With the enable high, the E-clock has a period of 8 clocks when EDIV=0 and 16 when EDIV=1. It is low for the first half of each period and high for the second half. With the enable low, the E-clock is 0.
- R10: A change of EDIV takes effect only after the current E-clock period completes.
- R11: Outside a stop, the system-interface clock comes from the VCO. During a stop, STSIM=0 selects the crystal and switches the VCO off, and STSIM=1 keeps the VCO.
- R12: Outside a stop, the external clock output is driven. During a stop, STEXT=0 holds it negated and STEXT=1 drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_super | input | 1 | Privilege qualifier |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| lock_in | input | 1 | Lock indication from the analog loop |
| eclk_en | input | 1 | E-clock output enable from pin assignment |
| stop_req | input | 1 | Low-power stop request |
| relock_o | output | 1 | One-cycle relock request |
| vco_w | output | 1 | VCO speed tap |
| vco_x | output | 1 | Output divide-by-two select |
| vco_y | output | 6 | Feedback modulus field |
| eclk_out | output | 1 | E-clock |
| sim_on_vco | output | 1 | 1 = system-interface clock from VCO, 0 = crystal |
| vco_off | output | 1 | VCO power-down request |
| clkout_drive | output | 1 | 1 = external clock driven, 0 = held negated |

## Verification
The assertions assume that the lock input, the stop request and the E-clock enable are synchronous to the block clock. They also assume that a bus access lasts a single cycle, with the strobe and the direction stable through that cycle. The stimulus changes every input only in the low phase of the clock. Directed sequences cover exact lock-run lengths, EDIV flips in the middle of a period, and stop combinations. A constrained random phase then keeps bus writes sparse and mixes privileged and unprivileged accesses, so that every lock state is reached repeatedly.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    typedef enum logic [1:0] {
        LK_BOOT    = 2'd0,
        LK_ACQUIRE = 2'd1,
        LK_HELD    = 2'd2
    } lock_state_e;

    localparam int REG_W     = 16;
    localparam int Y_W       = 6;
    localparam int BIT_W     = 15;
    localparam int BIT_X     = 14;
    localparam int Y_LSB     = 8;
    localparam int BIT_EDIV  = 7;
    localparam int BIT_STSIM = 6;
    localparam int BIT_STEXT = 5;
    localparam int BIT_SLOCK = 0;
endpackage

// File: rtl/ccr_lock_tracker.sv
module ccr_lock_tracker #(
    parameter int LOCK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic relock_req,
    input  logic lock_in,
    input  logic vco_off,
    output logic slock
);
    import ccr_pkg::*;

    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    lock_state_e st_q, st_d;
    logic [CW-1:0] run_q, run_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LK_BOOT;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        unique case (st_q)
            LK_BOOT: begin
                run_d = '0;
                if (wr_req) st_d = relock_req ? LK_ACQUIRE : LK_HELD;
            end
            LK_ACQUIRE: begin
                if (relock_req || !lock_in) begin
                    run_d = '0;
                end else if (run_q == LAST) begin
                    st_d  = LK_HELD;
                    run_d = '0;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end
            LK_HELD: begin
                run_d = '0;
                if (relock_req || !lock_in) st_d = LK_ACQUIRE;
            end
            default: begin
                st_d  = LK_BOOT;
                run_d = '0;
            end
        endcase
    end

    always_comb begin
        slock = (st_q != LK_ACQUIRE) || vco_off;
    end
endmodule

// File: rtl/ccr_eclk_div.sv
module ccr_eclk_div #(
    parameter int DIV_FAST = 8,
    parameter int DIV_SLOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ediv,
    input  logic eclk_en,
    output logic eclk_out
);
    localparam int CW = $clog2(DIV_SLOW);
    localparam logic [CW-1:0] TC_FAST   = CW'(DIV_FAST - 1);
    localparam logic [CW-1:0] TC_SLOW   = CW'(DIV_SLOW - 1);
    localparam logic [CW-1:0] HALF_FAST = CW'(DIV_FAST / 2);
    localparam logic [CW-1:0] HALF_SLOW = CW'(DIV_SLOW / 2);

    logic [CW-1:0] cnt_q;
    logic          slow_q;
    logic          term;

    assign term = (cnt_q == (slow_q ? TC_SLOW : TC_FAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slow_q <= 1'b0;
        end else if (term) begin
            cnt_q  <= '0;
            slow_q <= ediv;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign eclk_out = eclk_en && (cnt_q >= (slow_q ? HALF_SLOW : HALF_FAST));
endmodule

// File: rtl/ccr_stop_route.sv
module ccr_stop_route (
    input  logic stop_req,
    input  logic stsim,
    input  logic stext,
    output logic sim_on_vco,
    output logic vco_off,
    output logic clkout_drive
);
    always_comb begin
        sim_on_vco   = !stop_req || stsim;
        vco_off      = stop_req && !stsim;
        clkout_drive = !stop_req || stext;
    end
endmodule

// File: rtl/clk_ctrl_unit.sv
module clk_ctrl_unit #(
    parameter int LOCK_CYCLES = 4,
    parameter int DIV_FAST    = 8,
    parameter int DIV_SLOW    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_wr,
    input  logic        bus_super,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        lock_in,
    input  logic        eclk_en,
    input  logic        stop_req,
    output logic        relock_o,
    output logic        vco_w,
    output logic        vco_x,
    output logic [5:0]  vco_y,
    output logic        eclk_out,
    output logic        sim_on_vco,
    output logic        vco_off,
    output logic        clkout_drive
);
    import ccr_pkg::*;

    logic           w_q, x_q, ediv_q, stsim_q, stext_q, relock_q;
    logic [Y_W-1:0] y_q;
    logic           sup_wr, sup_rd, loop_chg, slock;
    logic [REG_W-1:0] word;

    assign sup_wr   = bus_en && bus_wr && bus_super;
    assign sup_rd   = bus_en && !bus_wr && bus_super;
    assign loop_chg = sup_wr && ((bus_wdata[BIT_W] != w_q) ||
                                 (bus_wdata[Y_LSB +: Y_W] != y_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q      <= 1'b0;
            x_q      <= 1'b0;
            y_q      <= '1;
            ediv_q   <= 1'b0;
            stsim_q  <= 1'b0;
            stext_q  <= 1'b0;
            relock_q <= 1'b0;
        end else begin
            relock_q <= loop_chg;
            if (sup_wr) begin
                w_q     <= bus_wdata[BIT_W];
                x_q     <= bus_wdata[BIT_X];
                y_q     <= bus_wdata[Y_LSB +: Y_W];
                ediv_q  <= bus_wdata[BIT_EDIV];
                stsim_q <= bus_wdata[BIT_STSIM];
                stext_q <= bus_wdata[BIT_STEXT];
            end
        end
    end

    always_comb begin
        word            = '0;
        word[BIT_W]     = w_q;
        word[BIT_X]     = x_q;
        word[Y_LSB +: Y_W] = y_q;
        word[BIT_EDIV]  = ediv_q;
        word[BIT_STSIM] = stsim_q;
        word[BIT_STEXT] = stext_q;
        word[BIT_SLOCK] = slock;
        bus_rdata       = sup_rd ? word : '0;
    end

    assign relock_o = relock_q;
    assign vco_w    = w_q;
    assign vco_x    = x_q;
    assign vco_y    = y_q;

    ccr_lock_tracker #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (sup_wr),
        .relock_req (loop_chg),
        .lock_in    (lock_in),
        .vco_off    (vco_off),
        .slock      (slock)
    );

    ccr_eclk_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_ediv (
        .clk      (clk),
        .rst_n    (rst_n),
        .ediv     (ediv_q),
        .eclk_en  (eclk_en),
        .eclk_out (eclk_out)
    );

    ccr_stop_route u_stop (
        .stop_req     (stop_req),
        .stsim        (stsim_q),
        .stext        (stext_q),
        .sim_on_vco   (sim_on_vco),
        .vco_off      (vco_off),
        .clkout_drive (clkout_drive)
    );
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_wr,
    input logic        bus_super,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        relock_o,
    input logic        vco_w,
    input logic        vco_x,
    input logic [5:0]  vco_y,
    input logic        slock,
    input logic        stop_req,
    input logic        sim_on_vco,
    input logic        vco_off,
    input logic        clkout_drive
);
    logic user_wr, chg_wr;
    assign user_wr = bus_en && bus_wr && !bus_super;
    assign chg_wr  = bus_en && bus_wr && bus_super &&
                     ((bus_wdata[15] != vco_w) || (bus_wdata[13:8] != vco_y));

    // R1
    a_r1_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        user_wr |=> $stable({vco_w, vco_x, vco_y}));

    // R2
    a_r2_user_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && !bus_super) |-> (bus_rdata == 16'h0000));

    // R4
    a_r4_relock_follows_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg_wr |=> relock_o);

    // R5
    a_r5_no_spurious_relock: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_wr |=> !relock_o);

    // R4
    a_r4_slock_low_on_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (relock_o && !vco_off) |-> !slock);

    // R8
    a_r8_slock_when_vco_off: assert property (@(posedge clk) disable iff (!rst_n)
        vco_off |-> slock);

    // R11
    a_r11_vco_off_excludes_vco: assert property (@(posedge clk) disable iff (!rst_n)
        vco_off |-> (!sim_on_vco && stop_req));

    // R12
    a_r12_clkout_outside_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req |-> clkout_drive);
endmodule

bind clk_ctrl_unit ccr_checker u_ccr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en       (bus_en),
    .bus_wr       (bus_wr),
    .bus_super    (bus_super),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .relock_o     (relock_o),
    .vco_w        (vco_w),
    .vco_x        (vco_x),
    .vco_y        (vco_y),
    .slock        (slock),
    .stop_req     (stop_req),
    .sim_on_vco   (sim_on_vco),
    .vco_off      (vco_off),
    .clkout_drive (clkout_drive)
);

// File: tb/test_clk_ctrl_unit.sv
module test_clk_ctrl_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_wr = 1'b0, bus_super = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        lock_in = 1'b0, eclk_en = 1'b0, stop_req = 1'b0;
    logic [15:0] bus_rdata;
    logic        relock_o, vco_w, vco_x, eclk_out, sim_on_vco, vco_off, clkout_drive;
    logic [5:0]  vco_y;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_ctrl_unit i_clk_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_super(bus_super), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_in(lock_in), .eclk_en(eclk_en), .stop_req(stop_req),
        .relock_o(relock_o), .vco_w(vco_w), .vco_x(vco_x), .vco_y(vco_y),
        .eclk_out(eclk_out), .sim_on_vco(sim_on_vco), .vco_off(vco_off),
        .clkout_drive(clkout_drive)
    );

    // Behavioural reference model
    int  m_w, m_x, m_y, m_ediv, m_stsim, m_stext;
    bit  m_written, m_locked, m_relock;
    int  m_run, m_ph, m_per;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_w = 0; m_x = 0; m_y = 63; m_ediv = 0; m_stsim = 0; m_stext = 0;
            m_written = 0; m_locked = 0; m_relock = 0; m_run = 0;
            m_ph = 0; m_per = 8;
        end else begin
            bit wr, chg;
            if (m_ph == m_per - 1) begin
                m_ph = 0;
                m_per = (m_ediv != 0) ? 16 : 8;
            end else m_ph++;
            wr  = bus_en && bus_wr && bus_super;
            chg = wr && ((int'(bus_wdata[15]) != m_w) || (int'(bus_wdata[13:8]) != m_y));
            m_relock = chg;
            if (chg) begin
                m_written = 1; m_locked = 0; m_run = 0;
            end else if (wr && !m_written) begin
                m_written = 1; m_locked = 1; m_run = 0;
            end else if (m_written) begin
                if (m_locked) begin
                    if (!lock_in) begin m_locked = 0; m_run = 0; end
                end else if (lock_in) begin
                    m_run++;
                    if (m_run == 4) begin m_locked = 1; m_run = 0; end
                end else m_run = 0;
            end
            if (wr) begin
                m_w = bus_wdata[15]; m_x = bus_wdata[14]; m_y = bus_wdata[13:8];
                m_ediv = bus_wdata[7]; m_stsim = bus_wdata[6]; m_stext = bus_wdata[5];
            end
        end
    end

    task automatic chk(input string tag, input string fld, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, fld, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        int e_voff, e_slock, e_rd;
        e_voff  = (stop_req && m_stsim == 0) ? 1 : 0;
        e_slock = (!m_written || m_locked || e_voff != 0) ? 1 : 0;
        e_rd = 0;
        if (bus_en && !bus_wr && bus_super)
            e_rd = (m_w << 15) | (m_x << 14) | (m_y << 8) | (m_ediv << 7) |
                   (m_stsim << 6) | (m_stext << 5) | e_slock;
        chk(tag, "rdata", int'(bus_rdata), e_rd);
        chk(tag, "w", int'(vco_w), m_w);
        chk(tag, "x", int'(vco_x), m_x);
        chk(tag, "y", int'(vco_y), m_y);
        chk(tag, "relock", int'(relock_o), int'(m_relock));
        chk(tag, "eclk", int'(eclk_out), (eclk_en && m_ph >= m_per / 2) ? 1 : 0);
        chk(tag, "sim_on_vco", int'(sim_on_vco), (!stop_req || m_stsim != 0) ? 1 : 0);
        chk(tag, "vco_off", int'(vco_off), e_voff);
        chk(tag, "clkout", int'(clkout_drive), (!stop_req || m_stext != 0) ? 1 : 0);
    endtask

    task automatic tick(input string tag, input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            compare(tag);
        end
    endtask

    task automatic idle();
        bus_en = 0; bus_wr = 0; bus_super = 0;
    endtask

    task automatic wr(input string tag, input bit sup, input logic [15:0] d);
        bus_en = 1; bus_wr = 1; bus_super = sup; bus_wdata = d;
        tick(tag);
        idle();
    endtask

    task automatic rd(input string tag, input bit sup);
        bus_en = 1; bus_wr = 0; bus_super = sup;
        tick(tag);
        idle();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick("R3", 3);
        rst_n = 1;
        tick("R3", 2);
        rd("R3", 1);
        // R6: lock input ignored before first write
        lock_in = 0;
        tick("R6", 5);
        rd("R6", 1);
        // R1/R2: unprivileged access
        wr("R1", 0, 16'hFFE0);
        rd("R1", 1);
        rd("R2", 0);
        // R5: first write keeps loop (X only) -> held
        lock_in = 1;
        wr("R5", 1, 16'h7F00);
        rd("R5", 1);
        // R4: Y change -> relock
        wr("R4", 1, 16'h7A00);
        rd("R4", 1);
        // R7: interrupted run
        lock_in = 1; tick("R7", 2);
        lock_in = 0; tick("R7", 1);
        lock_in = 1; tick("R7", 3);
        rd("R7", 1);
        tick("R7", 1);
        rd("R7", 1);
        lock_in = 0; rd("R7", 1);
        lock_in = 1; tick("R7", 5);
        // R4: W change
        wr("R4", 1, 16'hBA00);
        tick("R4", 5);
        // R9/R10: E-clock rates and mid-period EDIV flip
        eclk_en = 1;
        tick("R9", 20);
        wr("R10", 1, 16'hBA80);
        tick("R10", 40);
        wr("R10", 1, 16'hBA00);
        tick("R9", 20);
        eclk_en = 0; tick("R9", 10); eclk_en = 1;
        // R11/R12/R8: stop routing
        stop_req = 1; lock_in = 0;
        rd("R8", 1);
        tick("R11", 3);
        wr("R12", 1, 16'hBA20);
        tick("R12", 3);
        wr("R11", 1, 16'hBA60);
        rd("R11", 1);
        stop_req = 0; lock_in = 1;
        tick("R11", 6);
        rd("R7", 1);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            bus_en    = ($urandom_range(0, 7) == 0);
            bus_wr    = $urandom_range(0, 1);
            bus_super = ($urandom_range(0, 3) != 0);
            bus_wdata = ($urandom_range(0, 3) == 0) ? 16'($urandom) :
                        {vco_w, 1'($urandom), vco_y, 8'($urandom)};
            lock_in   = ($urandom_range(0, 5) != 0);
            eclk_en   = ($urandom_range(0, 15) != 0);
            stop_req  = ($urandom_range(0, 9) == 0);
            tick("R7");
        end
        idle();
        tick("R9", 4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule